// File: doc/BRIEF.md
# Quadratic Equation Solver over GF(2^89)

This block solves the characteristic-2 quadratic z^2 + z = a for an 89-bit field element a. The field is GF(2^89) in polynomial basis, with reduction modulo the trinomial u^89 + u^38 + 1. Over GF(2) the map z -> z^2 + z is linear. The solution is therefore a pure XOR network. It is built from repeated field squarings that accumulate a half-trace of the input. It serves as the root-finding step of an elliptic-curve point-halving data path, which lies outside this block.

The equation has a solution only when the field trace of a is zero. The block then has two roots, z and z + 1, which differ only in bit 0. The block always returns the root whose bit 0 is clear. A flag reports solvability. When the trace is one, the value returned satisfies z^2 + z = a + 1 instead. A registered wrapper captures the input on a strobe and presents the result one clock later. A parameter can reduce the wrapper to a plain combinational path.

Top module: `quad_solver`

## Requirements
- R1: When `sol_ok` is 1 and `res_valid` is 1, the output satisfies z^2 + z = a in GF(2^89), where bit i of a vector is the coefficient of u^i and reduction uses u^89 = u^38 + 1. Here a is the input captured with the matching strobe.
- R2: Bit 0 of `z_out` is always 0 when `res_valid` is 1, so the block picks the root of the pair {z, z+1} whose constant coefficient is 0.
- R3: `sol_ok` is 1 exactly when the field trace of a (the sum of a^(2^i) for i = 0..88) is 0. When the trace is 1, `sol_ok` is 0 and z^2 + z = a + 1, which is a with bit 0 inverted.
- R4: An all-zero input gives `z_out` = 0 and `sol_ok` = 1.
- R5: With `REGISTERED` = 1, `res_valid` is 1 in the cycle after a cycle with `op_valid` = 1, and 0 in the cycle after a cycle with `op_valid` = 0.
- R6: With `REGISTERED` = 1, a cycle with `op_valid` = 0 leaves `z_out` and `sol_ok` unchanged in the next cycle, whatever value `op_a` carries.
- R7: A synchronous active-high `rst` clears `res_valid`, `z_out` and `sol_ok` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Strobe that marks `op_a` as a new operand |
| op_a | input | 89 | Right-hand side a of z^2 + z = a |
| res_valid | output | 1 | Result is present for the operand strobed one cycle earlier |
| z_out | output | 89 | Root with bit 0 equal to 0 |
| sol_ok | output | 1 | 1 when the trace of a is 0 and z is a true root |

## Verification
Operands built as z^2 + z from a random z always have trace zero. They test whether the network finds a true root and then selects the right one of the pair. Unconstrained random operands reach both trace values, so they separate the solvability flag from the root bits and check the a + 1 relation for unsolvable inputs. Zero, one and single-bit powers of u probe the fold-back of the trinomial at the top indices and the constant term of the trace. Idle cycles that carry junk operands between strobes show whether the output register moves without a strobe.

// File: rtl/qs_pkg.sv
package qs_pkg;

    localparam int FIELD_N = 89;
    localparam int FIELD_K = 38;

    typedef logic [FIELD_N-1:0] gf_elem_t;

    typedef struct packed {
        logic     valid;
        gf_elem_t root;
        logic     solvable;
    } qs_result_t;

endpackage

// File: rtl/qs_square.sv
module qs_square #(
    parameter int N = qs_pkg::FIELD_N,
    parameter int K = qs_pkg::FIELD_K
) (
    input  logic [N-1:0] x,
    output logic [N-1:0] y
);
    localparam int W = 2 * N - 1;

    logic [W-1:0] spread;

    // Squaring moves bit i to position 2i. Low-half bits land on even indices.
    // High-half bits are folded back by the trinomial from the top down.
    always_comb begin
        spread = '0;
        for (int i = 0; i < N; i++) begin
            spread[2*i] = x[i];
        end
        for (int j = W - 1; j >= N; j--) begin
            spread[j-N]   = spread[j-N]   ^ spread[j];
            spread[j-N+K] = spread[j-N+K] ^ spread[j];
            spread[j]     = 1'b0;
        end
        y = spread[N-1:0];
    end

endmodule

// File: rtl/qs_halftrace.sv
module qs_halftrace #(
    parameter int N = qs_pkg::FIELD_N,
    parameter int K = qs_pkg::FIELD_K
) (
    input  logic [N-1:0] a,
    output logic [N-1:0] h
);
    localparam int STEPS = (N - 1) / 2;

    logic [N-1:0] pw  [STEPS+1];
    logic [N-1:0] mid [STEPS];
    logic [N-1:0] acc [STEPS+1];

    assign pw[0]  = a;
    assign acc[0] = a;

    // Each stage raises the running power by 4 (two squarings) and adds it in.
    for (genvar s = 0; s < STEPS; s++) begin : g_stage
        qs_square #(.N(N), .K(K)) u_sq_a (.x(pw[s]),  .y(mid[s]));
        qs_square #(.N(N), .K(K)) u_sq_b (.x(mid[s]), .y(pw[s+1]));
        assign acc[s+1] = acc[s] ^ pw[s+1];
    end

    assign h = acc[STEPS];

endmodule

// File: rtl/qs_core.sv
module qs_core #(
    parameter int N = qs_pkg::FIELD_N,
    parameter int K = qs_pkg::FIELD_K
) (
    input  logic [N-1:0] a,
    output logic [N-1:0] root,
    output logic         solvable,
    output logic [N-1:0] residue
);
    logic [N-1:0] ht;
    logic [N-1:0] ht_sq;

    qs_halftrace #(.N(N), .K(K)) u_ht (.a(a), .h(ht));
    qs_square    #(.N(N), .K(K)) u_sq (.x(ht), .y(ht_sq));

    // H^2 + H = a + Tr(a), so the residue is 0 or the constant 1.
    assign residue  = ht_sq ^ ht ^ a;
    assign solvable = ~residue[0];
    // The two roots differ only in the constant term. Keep the one with bit 0 clear.
    assign root     = {ht[N-1:1], 1'b0};

endmodule

// File: rtl/quad_solver.sv
module quad_solver #(
    parameter int N          = qs_pkg::FIELD_N,
    parameter int K          = qs_pkg::FIELD_K,
    parameter bit REGISTERED = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         op_valid,
    input  logic [N-1:0] op_a,
    output logic         res_valid,
    output logic [N-1:0] z_out,
    output logic         sol_ok
);
    logic [N-1:0] core_root;
    logic         core_solv;
    logic [N-1:0] core_res;

    qs_core #(.N(N), .K(K)) u_core (
        .a        (op_a),
        .root     (core_root),
        .solvable (core_solv),
        .residue  (core_res)
    );

    // Independent squarer on the presented root, used only by the checks below.
    logic [N-1:0] out_sq;
    qs_square #(.N(N), .K(K)) u_chk_sq (.x(z_out), .y(out_sq));

    if (REGISTERED) begin : g_reg
        logic         v_q;
        logic [N-1:0] z_q;
        logic         s_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                z_q <= '0;
                s_q <= 1'b0;
            end else begin
                v_q <= op_valid;
                if (op_valid) begin
                    z_q <= core_root;
                    s_q <= core_solv;
                end
            end
        end

        assign res_valid = v_q;
        assign z_out     = z_q;
        assign sol_ok    = s_q;

        AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
            op_valid |=> res_valid); // R5
        AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
            !op_valid |=> !res_valid); // R5
        AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
            (!op_valid && !$past(rst)) |=> ($stable(z_out) && $stable(sol_ok))); // R6
        AST_ROOT_VALID: assert property (@(posedge clk) disable iff (rst)
            (res_valid && sol_ok) |-> ((out_sq ^ z_out) == $past(op_a))); // R1
        AST_UNSOLVABLE_SHIFT: assert property (@(posedge clk) disable iff (rst)
            (res_valid && !sol_ok) |-> ((out_sq ^ z_out) == ($past(op_a) ^ {{(N-1){1'b0}}, 1'b1}))); // R3
        AST_RESIDUE_SCALAR: assert property (@(posedge clk) disable iff (rst)
            op_valid |-> (core_res[N-1:1] == '0)); // R3
    end else begin : g_comb
        assign res_valid = op_valid;
        assign z_out     = core_root;
        assign sol_ok    = core_solv;

        AST_COMB_RESIDUE: assert property (@(posedge clk) disable iff (rst)
            op_valid |-> ((out_sq ^ z_out) == (op_a ^ {{(N-1){1'b0}}, ~sol_ok}))); // R1
        AST_COMB_SCALAR: assert property (@(posedge clk) disable iff (rst)
            op_valid |-> (core_res[N-1:1] == '0)); // R3
    end

endmodule

// File: tb/tb_quad_solver.sv
module tb_quad_solver;
    localparam int N = 89;

    logic         clk = 1'b0;
    logic         rst;
    logic         op_valid;
    logic [N-1:0] op_a;
    logic         res_valid;
    logic [N-1:0] z_out;
    logic         sol_ok;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 1'b0;

    always #5 clk = ~clk;

    quad_solver dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_a(op_a),
        .res_valid(res_valid), .z_out(z_out), .sol_ok(sol_ok)
    );

    // Behavioural field arithmetic: shift-and-add multiply with u^89 = u^38 + 1.
    function automatic logic [N-1:0] f_mul(input logic [N-1:0] x, input logic [N-1:0] y);
        logic [N-1:0] r;
        logic         c;
        r = '0;
        for (int i = N - 1; i >= 0; i--) begin
            c = r[N-1];
            r = r << 1;
            if (c) begin
                r[0]  = ~r[0];
                r[38] = ~r[38];
            end
            if (y[i]) r = r ^ x;
        end
        return r;
    endfunction

    function automatic logic f_trace(input logic [N-1:0] x);
        logic [N-1:0] t;
        logic [N-1:0] s;
        t = x;
        s = '0;
        for (int i = 0; i < N; i++) begin
            s = s ^ t;
            t = f_mul(t, t);
        end
        return s[0];
    endfunction

    function automatic logic [N-1:0] rnd_elem();
        logic [95:0] w;
        w = {$urandom, $urandom, $urandom};
        return w[N-1:0];
    endfunction

    // Reference queue: one entry per clock, describing the expected output.
    logic         pend_v = 1'b0;
    logic [N-1:0] pend_a = '0;
    logic [N-1:0] last_z = '0;
    logic         last_s = 1'b0;

    task automatic check(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic compare_now();
        logic [N-1:0] lhs;
        logic         tr;
        check(res_valid == pend_v, "R5 res_valid", {88'b0, res_valid}, {88'b0, pend_v});
        if (pend_v) begin
            tr  = f_trace(pend_a);
            lhs = f_mul(z_out, z_out) ^ z_out;
            check(z_out[0] == 1'b0, "R2 root bit0", z_out, z_out & ~{{(N-1){1'b0}}, 1'b1});
            check(sol_ok == ~tr, "R3 sol_ok", {88'b0, sol_ok}, {88'b0, ~tr});
            if (!tr) check(lhs == pend_a, "R1 z^2+z", lhs, pend_a);
            else     check(lhs == (pend_a ^ 1), "R3 z^2+z=a+1", lhs, pend_a ^ 1);
            if (pend_a == '0)
                check(z_out == '0 && sol_ok, "R4 zero input", z_out, '0);
            last_z = z_out;
            last_s = sol_ok;
        end else begin
            check(z_out == last_z && sol_ok == last_s, "R6 hold", z_out, last_z);
        end
    endtask

    task automatic drive(input logic v, input logic [N-1:0] a);
        @(negedge clk);
        compare_now();
        op_valid = v;
        op_a     = a;
        pend_v   = v;
        pend_a   = a;
    endtask

    initial begin
        logic [N-1:0] z;
        rst      = 1'b1;
        op_valid = 1'b1;
        op_a     = '1;
        repeat (3) @(negedge clk);
        check(res_valid == 1'b0 && sol_ok == 1'b0 && z_out == '0, "R7 reset", z_out, '0);
        op_valid = 1'b0;
        op_a     = '0;
        @(negedge clk);
        rst = 1'b0;

        drive(1'b1, '0);                       // R4
        drive(1'b0, rnd_elem());               // R6 junk while idle
        drive(1'b1, {{(N-1){1'b0}}, 1'b1});    // R3: trace of 1 is 1
        drive(1'b0, '1);
        for (int k = 0; k < N; k += 4) begin   // single powers of u
            drive(1'b1, {{(N-1){1'b0}}, 1'b1} << k);
        end
        drive(1'b1, {{(N-1){1'b0}}, 1'b1} << (N - 1));
        drive(1'b1, '1);

        for (int i = 0; i < 250; i++) begin    // trace-0 operands, R1/R2
            z = rnd_elem();
            drive(1'b1, f_mul(z, z) ^ z);
            if (i % 7 == 3) drive(1'b0, rnd_elem());
        end
        for (int i = 0; i < 200; i++) begin    // unconstrained operands, R3
            drive(($urandom % 4) != 0, rnd_elem());
        end

        // Reset in mid-stream, R7
        drive(1'b1, rnd_elem());
        @(negedge clk);
        compare_now();
        rst      = 1'b1;
        op_valid = 1'b0;
        @(negedge clk);
        check(res_valid == 1'b0 && sol_ok == 1'b0 && z_out == '0, "R7 reset mid-run", z_out, '0);
        rst    = 1'b0;
        pend_v = 1'b0;
        last_z = '0;
        last_s = 1'b0;
        drive(1'b0, rnd_elem());
        drive(1'b0, '0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule